// File: doc/BRIEF.md
# Strobe-Masked Read Data Combiner

This block forms the read response of a memory-mapped register block. The address decoder hands it one read strobe per readable register, and the field logic hands it each register's assembled value. When a read request pulse arrives, every register value is masked by its own strobe. The masked values are then OR-folded into a single bus-wide word. No second address comparison takes place, because the decoder's strobes already select the register.

Each masked entry carries an extra hit bit that is set only when its strobe is active. If that bit folds to zero, no register matched the address. The read is then acknowledged with an error flag and a zero data word. A parameter can split the OR fold into two registered stages. The first stage ORs groups of about the square root of the register count, rounded down so that the final stage has the wider fan-in. The partial results are registered in the request cycle, so the returned value is the one that existed when any read side effect took place.

Top module: `rdmux_or`

## Requirements
- R1: On a read request with exactly one strobe bit set, the acknowledged read word equals the value of the register whose strobe is set (strobe bit i selects slice i of the packed value input, bits i*DATA_W upward).
- R2: The error flag is low on an acknowledged read that hit a register. It is high, with a zero read word, on an acknowledged read whose strobe vector is all zero.
- R3: The acknowledge is a one-cycle pulse per request. With PIPE=0 it is high in the request cycle. With PIPE=1 it is high exactly one cycle after the request and low in the request cycle itself.
- R4: While the acknowledge is low, the read word and the error flag are zero, even if strobes are active without a request.
- R5: With PIPE=1, the returned word is the register value present in the request cycle. A change to that register in the following cycle does not alter it.
- R6: After reset, the acknowledge, error flag and read word are all zero.
- R7: With PIPE=1, requests in consecutive cycles are acknowledged in consecutive cycles, in order, each with its own register's value.
- R8: With PIPE=1, every register returns correctly when the register count is not a perfect square, including the members of the last, partially filled group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdReq | input | 1 | Read request pulse |
| rdStrb | input | NUM_REGS | Per-register read strobes from the decoder |
| regVals | input | NUM_REGS*DATA_W | Packed register values, register i in bits i*DATA_W upward |
| rdAck | output | 1 | Read acknowledge pulse |
| rdData | output | DATA_W | Read word, valid with rdAck |
| rdErr | output | 1 | Unmapped-read flag, valid with rdAck |

## Verification
The assertions assume that the decoder raises at most one strobe per request and holds the strobes at zero when no request is present. They also assume that the request is low during reset. The stimulus drives strobes only as a one-hot or all-zero vector. It changes inputs on the falling clock edge and keeps the request low throughout reset. One idle case drives a strobe without a request, to show that the outputs stay zero.

// File: rtl/rdmux_pkg.sv
package rdmux_pkg;

  typedef struct packed {
    logic qual;  // request qualifies the strobes this cycle
    logic ack;   // response is presented this cycle
  } rdCtl_t;

  // Largest integer whose square does not exceed n.
  function automatic int isqrt(input int n);
    int r;
    r = 1;
    for (int k = 1; k <= n; k++) begin
      if (k * k <= n) r = k;
    end
    return r;
  endfunction

endpackage

// File: rtl/rdmux_ctrl.sv
module rdmux_ctrl
  import rdmux_pkg::*;
#(
  parameter int PIPE = 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rdReq,
  output rdCtl_t ctl,
  output logic   rdAck
);

  logic ackNow;

  generate
    if (PIPE != 0) begin : g_seq
      logic reqQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) reqQ <= 1'b0;
        else       reqQ <= rdReq;
      end
      assign ackNow = reqQ;
    end else begin : g_comb
      assign ackNow = rdReq;
    end
  endgenerate

  assign ctl.qual = rdReq;
  assign ctl.ack  = ackNow;
  assign rdAck    = ackNow;

endmodule

// File: rtl/rdmux_data.sv
module rdmux_data
  import rdmux_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int PIPE     = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rdCtl_t                     ctl,
  input  logic [NUM_REGS-1:0]        rdStrb,
  input  logic [NUM_REGS*DATA_W-1:0] regVals,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdErr
);

  localparam int GRP  = (PIPE != 0) ? isqrt(NUM_REGS) : NUM_REGS;
  localparam int NGRP = (NUM_REGS + GRP - 1) / GRP;
  localparam int NPAD = NGRP * GRP;
  localparam int EW   = DATA_W + 1;  // data plus hit bit

  logic [EW-1:0] entry [NPAD];
  logic [EW-1:0] part  [NGRP];
  logic [EW-1:0] stage [NGRP];
  logic [EW-1:0] fin;

  // Strobe-masked entries; the top bit marks a hit.
  generate
    for (genvar i = 0; i < NPAD; i++) begin : g_entry
      if (i < NUM_REGS) begin : g_real
        assign entry[i] = {EW{ctl.qual & rdStrb[i]}}
                        & {1'b1, regVals[i*DATA_W +: DATA_W]};
      end else begin : g_pad
        assign entry[i] = '0;
      end
    end
  endgenerate

  // First-level OR over each group.
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_part
      always_comb begin
        part[g] = '0;
        for (int k = 0; k < GRP; k++) part[g] = part[g] | entry[g*GRP + k];
      end
    end
  endgenerate

  // Optional register between the two OR levels.
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_stage
      if (PIPE != 0) begin : g_reg
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= '0;
          else       stage[g] <= part[g];
        end
      end else begin : g_wire
        assign stage[g] = part[g];
      end
    end
  endgenerate

  // Second-level OR across groups.
  always_comb begin
    fin = '0;
    for (int g = 0; g < NGRP; g++) fin = fin | stage[g];
  end

  assign rdData = fin[DATA_W-1:0] & {DATA_W{ctl.ack}};
  assign rdErr  = ctl.ack & ~fin[DATA_W];

endmodule

// File: rtl/rdmux_or.sv
module rdmux_or
  import rdmux_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int PIPE     = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdReq,
  input  logic [NUM_REGS-1:0]        rdStrb,
  input  logic [NUM_REGS*DATA_W-1:0] regVals,
  output logic                       rdAck,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdErr
);

  rdCtl_t ctl;

  rdmux_ctrl #(.PIPE(PIPE)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .rdReq (rdReq),
    .ctl   (ctl),
    .rdAck (rdAck)
  );

  rdmux_data #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PIPE(PIPE)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .rdStrb  (rdStrb),
    .regVals (regVals),
    .rdData  (rdData),
    .rdErr   (rdErr)
  );

endmodule

// File: rtl/rdmux_or_chk.sv
module rdmux_or_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int PIPE     = 1
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       rdReq,
  input logic [NUM_REGS-1:0]        rdStrb,
  input logic                       rdAck,
  input logic [DATA_W-1:0]          rdData,
  input logic                       rdErr
);

  p_ack_same_r3: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE == 0 && rdReq) |-> rdAck);

  p_ack_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE != 0 && rdReq) |=> rdAck);

  p_ack_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE != 0 && rdAck) |-> $past(rdReq));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdAck |-> (rdData == '0 && !rdErr));

  p_miss_same_r2: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE == 0 && rdReq && rdStrb == '0) |-> (rdErr && rdData == '0));

  p_miss_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE != 0 && rdReq && rdStrb == '0) |=> (rdErr && rdData == '0));

  p_hit_same_r1: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE == 0 && rdReq && $onehot0(rdStrb) && rdStrb != '0) |-> !rdErr);

  p_hit_next_r1: assert property (@(posedge clk) disable iff (!rstN)
    (PIPE != 0 && rdReq && $onehot0(rdStrb) && rdStrb != '0) |=> !rdErr);

endmodule

bind rdmux_or rdmux_or_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PIPE(PIPE)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdReq  (rdReq),
  .rdStrb (rdStrb),
  .rdAck  (rdAck),
  .rdData (rdData),
  .rdErr  (rdErr)
);

// File: tb/test_rdmux_or.sv
`timescale 1ns/1ps
module test_rdmux_or;

  localparam int W  = 16;
  localparam int NC = 8;  // combinational instance
  localparam int NP = 7;  // pipelined instance, non-square count

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic            reqC = 1'b0, reqP = 1'b0;
  logic [NC-1:0]   strbC = '0;
  logic [NP-1:0]   strbP = '0;
  logic [NC*W-1:0] valsC;
  logic [NP*W-1:0] valsP;
  logic            ackC, ackP, errC, errP;
  logic [W-1:0]    dataC, dataP;

  int nTests = 0;
  int nFail  = 0;

  rdmux_or #(.NUM_REGS(NC), .DATA_W(W), .PIPE(0)) i_rdmux_or (
    .clk(clk), .rstN(rstN), .rdReq(reqC), .rdStrb(strbC), .regVals(valsC),
    .rdAck(ackC), .rdData(dataC), .rdErr(errC));

  rdmux_or #(.NUM_REGS(NP), .DATA_W(W), .PIPE(1)) i_rdmux_or_pipe (
    .clk(clk), .rstN(rstN), .rdReq(reqP), .rdStrb(strbP), .regVals(valsP),
    .rdAck(ackP), .rdData(dataP), .rdErr(errP));

  function automatic logic [W-1:0] valOf(input int i);
    return W'(16'h1357 + i * 16'h2461);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    check(ackC == 0 && dataC == 0 && errC == 0, "R6 comb reset", {ackC, errC, dataC}, 0);
    check(ackP == 0 && dataP == 0 && errP == 0, "R6 pipe reset", {ackP, errP, dataP}, 0);
  endtask

  task automatic t_comb_read(input int idx);
    @(negedge clk); reqC = 1; strbC = NC'(1) << idx; #1;
    check(ackC == 1, "R3 comb ack same cycle", ackC, 1);
    check(dataC == valOf(idx), "R1 comb data", dataC, valOf(idx));
    check(errC == 0, "R2 comb no err on hit", errC, 0);
    @(negedge clk); reqC = 0; strbC = '0; #1;
    check(ackC == 0 && dataC == 0, "R4 comb quiet after", {ackC, dataC}, 0);
  endtask

  task automatic t_comb_miss();
    @(negedge clk); reqC = 1; strbC = '0; #1;
    check(ackC == 1 && errC == 1 && dataC == 0, "R2 comb miss", {ackC, errC, dataC}, 32'h30000);
    @(negedge clk); reqC = 0;
  endtask

  task automatic t_comb_idle();
    @(negedge clk); reqC = 0; strbC = NC'(1) << 4; #1;
    check(ackC == 0 && errC == 0 && dataC == 0, "R4 strobe without request",
          {ackC, errC, dataC}, 0);
    @(negedge clk); strbC = '0;
  endtask

  task automatic t_pipe_read(input int idx);
    @(negedge clk); reqP = 1; strbP = NP'(1) << idx; #1;
    check(ackP == 0, "R3 pipe no ack in request cycle", ackP, 0);
    @(negedge clk); reqP = 0; strbP = '0; #1;
    check(ackP == 1, "R3 pipe ack one cycle later", ackP, 1);
    check(dataP == valOf(idx), "R1 R8 pipe data", dataP, valOf(idx));
    check(errP == 0, "R2 pipe no err on hit", errP, 0);
    @(negedge clk); #1;
    check(ackP == 0 && dataP == 0, "R3 pipe single pulse", {ackP, dataP}, 0);
  endtask

  task automatic t_pipe_miss();
    @(negedge clk); reqP = 1; strbP = '0;
    @(negedge clk); reqP = 0; #1;
    check(ackP == 1 && errP == 1 && dataP == 0, "R2 pipe miss", {ackP, errP, dataP}, 32'h30000);
  endtask

  task automatic t_pipe_hold();
    logic [W-1:0] orig;
    orig = valOf(3);
    @(negedge clk); reqP = 1; strbP = NP'(1) << 3;
    @(posedge clk); #1;
    valsP[3*W +: W] = ~orig; reqP = 0; strbP = '0; #1;
    check(ackP == 1 && dataP == orig, "R5 value sampled in request cycle", dataP, orig);
    @(negedge clk); valsP[3*W +: W] = orig;
  endtask

  task automatic t_pipe_b2b();
    @(negedge clk); reqP = 1; strbP = NP'(1) << 2;
    @(negedge clk); strbP = NP'(1) << 5; #1;
    check(ackP == 1 && dataP == valOf(2), "R7 first of pair", dataP, valOf(2));
    @(negedge clk); reqP = 0; strbP = '0; #1;
    check(ackP == 1 && dataP == valOf(5), "R7 second of pair", dataP, valOf(5));
    @(negedge clk); #1;
    check(ackP == 0, "R7 pair ends", ackP, 0);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) valsC[i*W +: W] = valOf(i);
    for (int i = 0; i < NP; i++) valsP[i*W +: W] = valOf(i);
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    for (int i = 0; i < NC; i++) t_comb_read(i);
    t_comb_miss();
    t_comb_idle();
    for (int i = 0; i < NP; i++) t_pipe_read(i);
    t_pipe_miss();
    t_pipe_hold();
    t_pipe_b2b();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule